// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the sequencing core of a microprogrammed controller. A control address register selects one word of an on-chip control store. That word is registered into a control buffer, and the buffer's horizontal bits drive the control lines of an external datapath directly. Each stored word also carries a condition selector and a jump target. On every clock the sequencing logic picks the next control address from one of three sources: the current address plus one, the word's own jump target when the selected condition holds, or a start address mapped from the instruction opcode.

The microprogram is a fixed table inside the block. Its inputs are the opcode, the zero and negative flags of the ALU, and an interrupt request. Its outputs are the control-line vector and the current control address, which is brought out for observation. The control store is read synchronously. It is addressed by the next address as that address is registered, so the buffer always holds the word that belongs to the address shown on `upc_o`, and one microinstruction completes per clock.

Top module: `useq_ctrl`

## Requirements
- R1: While reset (active low, asynchronous) is held, `upc_o` is 0 and `ctrl_o` is all zero. The first clock edge after release moves `upc_o` to 1, because word 0 is an all-zero no-operation whose condition is "never".
- R2: After each edge, `ctrl_o` equals the control bits of the word at `upc_o`. The table is: 0→000, 1→001, 2→006, 3→008, 8→010, 9→020, 12→040, 16→080, 17→100, 20→200, 24→400, 25→800, 32→003, 33→00C, 34→030, 48→FFF (hex). Every other word is zero.
- R3: A word whose condition selector is 0 ("never"), or one of the unassigned codes 6 and 7, moves the address to the current address plus one, whatever its jump target. Word 33 uses code 6 with target 0 and must lead to 34.
- R4: Condition code 1 ("always") loads the word's jump target. Words 9, 12, 17, 20, 25, 34 and 48 all jump to address 1.
- R5: Condition code 2 jumps when the zero flag is 1 and otherwise steps by one. Word 8 targets 12, so it is followed by 12 or 9.
- R6: Condition code 3 jumps when the negative flag is 1 and otherwise steps by one. Word 16 targets 20, so it is followed by 20 or 17.
- R7: Condition code 4 jumps when the interrupt request is 1 and otherwise steps by one. Word 24 targets 48, so it is followed by 48 or 25.
- R8: Condition code 5 (word 3) loads 8 + opcode×8. With a 2-bit opcode the routine starts are 8, 16, 24 and 32.
- R9: Flags, interrupt request and opcode have no effect while the current word's condition does not select them. A "never" word with all flags high still steps by one.
- R10: The address advances on every clock edge. The fetch sequence after reset is 1, 2, 3, then dispatch, and every routine returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 2 | Opcode used by the dispatch condition |
| zero_i | input | 1 | ALU zero flag |
| neg_i | input | 1 | ALU negative flag |
| irq_i | input | 1 | Interrupt request |
| ctrl_o | output | 12 | Control lines from the buffer register |
| upc_o | output | 6 | Current control address |

## Verification
The bench uses the default parameters: a 6-bit control address, a 12-bit control word, a 2-bit opcode, a slot shift of 3 and a dispatch base of 8. With these values all four opcode routines can be reached. So can both outcomes of every flag-tested word, the interrupt service word at 48, and the reserved condition code at word 33. A trace that is followed address by address therefore covers every sequencing choice, and every word in the table except the unused zero words.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int AW         = 6;
    localparam int CW         = 12;
    localparam int OPW        = 2;
    localparam int CSW        = 3;
    localparam int SLOT_SHIFT = 3;
    localparam int MAP_BASE   = 8;
    localparam int DEPTH      = 1 << AW;

    localparam logic [CSW-1:0] C_NEVER    = 3'd0;
    localparam logic [CSW-1:0] C_ALWAYS   = 3'd1;
    localparam logic [CSW-1:0] C_ZERO     = 3'd2;
    localparam logic [CSW-1:0] C_NEG      = 3'd3;
    localparam logic [CSW-1:0] C_IRQ      = 3'd4;
    localparam logic [CSW-1:0] C_DISPATCH = 3'd5;

    typedef struct packed {
        logic [CW-1:0]  ctrl;
        logic [CSW-1:0] cond;
        logic [AW-1:0]  addr;
    } uword_t;

    function automatic logic [AW-1:0] map_op(input logic [OPW-1:0] op);
        return AW'(MAP_BASE) + (AW'(op) << SLOT_SHIFT);
    endfunction

    function automatic uword_t mk(input logic [CW-1:0] c, input logic [CSW-1:0] s,
                                  input logic [AW-1:0] a);
        uword_t w;
        w.ctrl = c;
        w.cond = s;
        w.addr = a;
        return w;
    endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    output uword_t        word_o
);
    // Fixed microprogram: fetch at 1..3, routines at 8 + op*8, service at 48.
    always_comb begin
        case (addr_i)
            6'd1:    word_o = mk(12'h001, C_NEVER,    6'd0);
            6'd2:    word_o = mk(12'h006, C_NEVER,    6'd0);
            6'd3:    word_o = mk(12'h008, C_DISPATCH, 6'd0);
            6'd8:    word_o = mk(12'h010, C_ZERO,     6'd12);
            6'd9:    word_o = mk(12'h020, C_ALWAYS,   6'd1);
            6'd12:   word_o = mk(12'h040, C_ALWAYS,   6'd1);
            6'd16:   word_o = mk(12'h080, C_NEG,      6'd20);
            6'd17:   word_o = mk(12'h100, C_ALWAYS,   6'd1);
            6'd20:   word_o = mk(12'h200, C_ALWAYS,   6'd1);
            6'd24:   word_o = mk(12'h400, C_IRQ,      6'd48);
            6'd25:   word_o = mk(12'h800, C_ALWAYS,   6'd1);
            6'd32:   word_o = mk(12'h003, C_NEVER,    6'd0);
            6'd33:   word_o = mk(12'h00C, 3'd6,       6'd0);
            6'd34:   word_o = mk(12'h030, C_ALWAYS,   6'd1);
            6'd48:   word_o = mk(12'hFFF, C_ALWAYS,   6'd1);
            default: word_o = '0;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uword_t         word_i,
    input  logic [AW-1:0]  car_i,
    input  logic [OPW-1:0] opcode_i,
    input  logic           zero_i,
    input  logic           neg_i,
    input  logic           irq_i,
    output logic [AW-1:0]  next_o
);
    logic take;
    logic disp;

    always_comb begin
        take = 1'b0;
        disp = 1'b0;
        case (word_i.cond)
            C_ALWAYS:   take = 1'b1;
            C_ZERO:     take = zero_i;
            C_NEG:      take = neg_i;
            C_IRQ:      take = irq_i;
            C_DISPATCH: disp = 1'b1;
            default:    take = 1'b0;
        endcase
        if (disp)      next_o = map_op(opcode_i);
        else if (take) next_o = word_i.addr;
        else           next_o = car_i + AW'(1);
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [OPW-1:0] opcode_i,
    input  logic           zero_i,
    input  logic           neg_i,
    input  logic           irq_i,
    output logic [CW-1:0]  ctrl_o,
    output logic [AW-1:0]  upc_o
);
    typedef struct packed {
        logic [AW-1:0] car;
        uword_t        cbr;
    } seq_t;

    seq_t          st_d, st_q;
    logic [AW-1:0] nxt;
    uword_t        rom_word;

    useq_next next_i (
        .word_i   (st_q.cbr),
        .car_i    (st_q.car),
        .opcode_i (opcode_i),
        .zero_i   (zero_i),
        .neg_i    (neg_i),
        .irq_i    (irq_i),
        .next_o   (nxt)
    );

    useq_rom rom_i (
        .addr_i (nxt),
        .word_o (rom_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.car = nxt;
        st_d.cbr = rom_word;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.cbr.ctrl;
    assign upc_o  = st_q.car;

    AST_STEP_ON_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cbr.cond == C_NEVER || st_q.cbr.cond > C_DISPATCH)
        |=> (upc_o == $past(upc_o) + AW'(1))); // R3
    AST_JUMP_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cbr.cond == C_ALWAYS) |=> (upc_o == $past(st_q.cbr.addr))); // R4
    AST_ZERO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cbr.cond == C_ZERO && zero_i) |=> (upc_o == $past(st_q.cbr.addr))); // R5
    AST_NEG_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cbr.cond == C_NEG && neg_i) |=> (upc_o == $past(st_q.cbr.addr))); // R6
    AST_IRQ_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cbr.cond == C_IRQ && !irq_i) |=> (upc_o == $past(upc_o) + AW'(1))); // R7
    AST_DISPATCH_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cbr.cond == C_DISPATCH)
        |=> (upc_o == AW'(MAP_BASE) + (AW'($past(opcode_i)) << SLOT_SHIFT))); // R8
endmodule

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  opcode_i = '0;
    logic        zero_i = 1'b0, neg_i = 1'b0, irq_i = 1'b0;
    logic [11:0] ctrl_o;
    logic [5:0]  upc_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [5:0]  a;
        logic [11:0] c;
        string       r;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #4 clk_i = ~clk_i;

    useq_ctrl dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i),
        .zero_i(zero_i), .neg_i(neg_i), .irq_i(irq_i),
        .ctrl_o(ctrl_o), .upc_o(upc_o)
    );

    // Monitor: compare each expected item shortly after the edge it belongs to.
    always @(posedge clk_i) begin
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (upc_o !== e.a || ctrl_o !== e.c) begin
                fails++;
                $display("FAIL %s: upc=%0d ctrl=%h expected upc=%0d ctrl=%h",
                         e.r, upc_o, ctrl_o, e.a, e.c);
            end
        end
    end

    // Driver: set inputs for the coming edge and queue the expected result.
    task automatic step(input logic [1:0] op, input logic z, input logic n, input logic irq,
                        input logic [5:0] a, input logic [11:0] c, input string r);
        exp_t x;
        @(negedge clk_i);
        opcode_i = op; zero_i = z; neg_i = n; irq_i = irq;
        x.a = a; x.c = c; x.r = r;
        q.push_back(x);
    endtask

    task automatic fetch_from_one();
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd2, 12'h006, "R10");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd3, 12'h008, "R2");
    endtask

    task automatic direct(input string r, input logic [5:0] a, input logic [11:0] c);
        checks++;
        if (upc_o !== a || ctrl_o !== c) begin
            fails++;
            $display("FAIL %s: upc=%0d ctrl=%h expected upc=%0d ctrl=%h", r, upc_o, ctrl_o, a, c);
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        direct("R1", 6'd0, 12'h000);
        rst_ni = 1'b1;
        q.push_back('{6'd1, 12'h001, "R1"});
        // R9: flags high under a "never" word are ignored
        step(2'd3, 1'b1, 1'b1, 1'b1, 6'd2, 12'h006, "R9");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd3, 12'h008, "R2");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd8, 12'h010, "R8");
        step(2'd0, 1'b1, 1'b0, 1'b0, 6'd12, 12'h040, "R5");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        fetch_from_one();
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd8, 12'h010, "R8");
        step(2'd0, 1'b0, 1'b1, 1'b1, 6'd9, 12'h020, "R5");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        fetch_from_one();
        step(2'd1, 1'b0, 1'b0, 1'b0, 6'd16, 12'h080, "R8");
        step(2'd0, 1'b0, 1'b1, 1'b0, 6'd20, 12'h200, "R6");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        fetch_from_one();
        step(2'd1, 1'b0, 1'b0, 1'b0, 6'd16, 12'h080, "R8");
        step(2'd0, 1'b1, 1'b0, 1'b1, 6'd17, 12'h100, "R6");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        fetch_from_one();
        step(2'd2, 1'b0, 1'b0, 1'b0, 6'd24, 12'h400, "R8");
        step(2'd0, 1'b0, 1'b0, 1'b1, 6'd48, 12'hFFF, "R7");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        fetch_from_one();
        step(2'd2, 1'b0, 1'b0, 1'b0, 6'd24, 12'h400, "R8");
        step(2'd0, 1'b1, 1'b1, 1'b0, 6'd25, 12'h800, "R7");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        fetch_from_one();
        step(2'd3, 1'b0, 1'b0, 1'b0, 6'd32, 12'h003, "R8");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd33, 12'h00C, "R3");
        step(2'd0, 1'b1, 1'b1, 1'b1, 6'd34, 12'h030, "R3");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd1, 12'h001, "R4");
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd2, 12'h006, "R10");
        repeat (3) @(posedge clk_i);
        // Reset in mid-run, then restart
        @(negedge clk_i);
        rst_ni = 1'b0;
        #1;
        direct("R1", 6'd0, 12'h000);
        @(negedge clk_i);
        direct("R1", 6'd0, 12'h000);
        rst_ni = 1'b1;
        q.push_back('{6'd1, 12'h001, "R1"});
        step(2'd0, 1'b0, 1'b0, 1'b0, 6'd2, 12'h006, "R10");
        repeat (3) @(posedge clk_i);
        #3;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule